// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the interrupt conditions of a set of DMA channels into one interrupt line. Every channel raises three kinds of event: block done, bus or descriptor fault, and channel halted. Each event sets a sticky flag for its channel. Software controls a per-channel enable for each flag and clears flags by writing ones to them. The aggregator shows which channels currently request service. It also names the lowest-numbered requesting channel together with that channel's raw flags, so a handler can serve channels in order without scanning the whole array.

Software reaches one channel at a time through an access port. The port carries a channel index, three write bits and three write strobes: enable-set, enable-clear and flag-clear. The same index selects the channel whose flags and enables appear on the read outputs. Bit positions are the same everywhere: bit 0 is done, bit 1 is fault and bit 2 is halted. A per-channel reset clears one channel. The asynchronous reset clears them all. A global interrupt-enable input gates only the combined line.

Top module: `dma_irq_aggregator`

## Requirements
- R1: A high event input sets the matching flag (bit 0 done, bit 1 fault, bit 2 halted) of that channel on the next clock edge. The flag then stays set until it is cleared.
- R2: A flag-clear write clears every flag bit of the addressed channel that is written as 1. Bits written as 0 keep their value. When an event and a clear of the same bit arrive in the same cycle, the flag ends up set.
- R3: An enable-set write sets the addressed channel's enable bits that are written as 1. An enable-clear write clears them. Zero bits have no effect. If both strobes write 1 to the same bit in the same cycle, the enable ends up cleared.
- R4: Bit i of `chan_pend` is high exactly while channel i has at least one flag set whose enable is also set.
- R5: `irq_out` is high when `glob_ie` is high and any bit of `chan_pend` is high. When `glob_ie` is low, `irq_out` is low and `chan_pend` is not affected.
- R6: When some channel is pending, `pend_valid` is 1, `pend_ch` gives the lowest pending channel number and `pend_flags` gives that channel's raw flags. When no channel is pending, all three outputs are 0.
- R7: A per-channel reset clears that channel's flags and enables on the next edge, and it wins over an event in the same cycle. Other channels are left unchanged.
- R8: The asynchronous reset clears all flags and enables of every channel.
- R9: `rd_flags` and `rd_enables` show the flags and enables of the channel selected by `acc_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| ch_rst | input | NUM_CH | Synchronous reset, one bit per channel |
| evt_done | input | NUM_CH | Block-done event, one bit per channel |
| evt_fault | input | NUM_CH | Fault event, one bit per channel |
| evt_halt | input | NUM_CH | Channel-halted event, one bit per channel |
| acc_ch | input | $clog2(NUM_CH) | Channel addressed by writes and reads |
| wr_bits | input | 3 | Write data (bit0 done, bit1 fault, bit2 halted) |
| we_en_set | input | 1 | Set-enable strobe |
| we_en_clr | input | 1 | Clear-enable strobe |
| we_flag_clr | input | 1 | Clear-flag strobe |
| rd_flags | output | 3 | Flags of the addressed channel |
| rd_enables | output | 3 | Enables of the addressed channel |
| glob_ie | input | 1 | Global gate for irq_out |
| irq_out | output | 1 | Combined interrupt request |
| chan_pend | output | NUM_CH | Per-channel pending status |
| pend_valid | output | 1 | Some channel is pending |
| pend_ch | output | $clog2(NUM_CH) | Lowest pending channel |
| pend_flags | output | 3 | Flags of that channel |

## Verification
The main sequence builds up overlapping state across channels 0, 2 and 5. Events arrive both before and after their enables. Flags and enables are dropped in turn, so each step shows whether a bit of `chan_pend` follows the AND of a flag and its enable, or wrongly follows only one of them. The choice of lowest channel is tested with a pending channel appearing both below and above the current winner, which separates lowest-first from highest-first or last-written selection. Directed steps then collide an event with a clear, an enable set with an enable clear, and a channel reset with an event. They also lower the global gate to show that it masks only the combined line.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
   localparam int unsigned SRC_CNT   = 3;
   localparam int unsigned SRC_DONE  = 0;
   localparam int unsigned SRC_FAULT = 1;
   localparam int unsigned SRC_HALT  = 2;
   typedef logic [SRC_CNT-1:0] src_vec_t;
endpackage

// File: rtl/irq_chan_slice.sv
module irq_chan_slice
   import dmairq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ch_rst,
   input  src_vec_t evt,
   input  logic     set_we,
   input  logic     clr_we,
   input  logic     fclr_we,
   input  src_vec_t wbits,
   output src_vec_t flags_q,
   output src_vec_t en_q,
   output logic     req
);
   src_vec_t flag_nxt, en_nxt, fclr_mask, set_mask, clr_mask;

   always_comb begin
      fclr_mask = fclr_we ? wbits : '0;
      set_mask  = set_we  ? wbits : '0;
      clr_mask  = clr_we  ? wbits : '0;
      // an event beats a clear of the same bit
      flag_nxt  = (flags_q & ~fclr_mask) | evt;
      // a clear beats a set of the same bit
      en_nxt    = (en_q | set_mask) & ~clr_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         en_q    <= '0;
      end else if (ch_rst) begin
         flags_q <= '0;
         en_q    <= '0;
      end else begin
         flags_q <= flag_nxt;
         en_q    <= en_nxt;
      end
   end

   assign req = |(flags_q & en_q);

   // R1
   evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt && !ch_rst) |=> ((flags_q & $past(evt)) == $past(evt)));
   // R2
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_rst && !fclr_we) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
   // R3
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we && !ch_rst) |=> ((en_q & $past(wbits)) == $past(wbits)));
   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !ch_rst) |=> ((en_q & $past(wbits)) == '0));
   // R7
   ch_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_rst |=> (flags_q == '0 && en_q == '0));
endmodule

// File: rtl/irq_low_enc.sv
module irq_low_enc #(
   parameter int unsigned N = 8,
   localparam int unsigned W = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_vec,
   output logic         hit,
   output logic [W-1:0] idx
);
   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   always_comb begin
      hit = 1'b0;
      idx = '0;
      // scan downward so the lowest request is written last
      for (int i = N - 1; i >= 0; i--) begin
         if (req_vec[i]) begin
            hit = 1'b1;
            idx = W'(i);
         end
      end
   end

   // R6
   pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (req_vec[idx] && ((req_vec & ((ONE << idx) - ONE)) == '0)));
   // R6
   none_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (req_vec == '0));
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_CH   = 8,
   parameter int unsigned REG_PEND = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         ch_rst,
   input  logic [NUM_CH-1:0]         evt_done,
   input  logic [NUM_CH-1:0]         evt_fault,
   input  logic [NUM_CH-1:0]         evt_halt,
   input  logic [$clog2(NUM_CH)-1:0] acc_ch,
   input  logic [2:0]                wr_bits,
   input  logic                      we_en_set,
   input  logic                      we_en_clr,
   input  logic                      we_flag_clr,
   output logic [2:0]                rd_flags,
   output logic [2:0]                rd_enables,
   input  logic                      glob_ie,
   output logic                      irq_out,
   output logic [NUM_CH-1:0]         chan_pend,
   output logic                      pend_valid,
   output logic [$clog2(NUM_CH)-1:0] pend_ch,
   output logic [2:0]                pend_flags
);
   localparam int unsigned CH_W = $clog2(NUM_CH);

   if (NUM_CH < 2 || NUM_CH > 1024) begin : g_bad_ch
      $error("NUM_CH must lie in 2..1024");
   end
   if (REG_PEND > 1) begin : g_bad_reg
      $error("REG_PEND must be 0 or 1");
   end

   src_vec_t flag_arr [NUM_CH];
   src_vec_t en_arr   [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel;
      assign sel = (acc_ch == CH_W'(c));
      irq_chan_slice u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .ch_rst  (ch_rst[c]),
         .evt     ({evt_halt[c], evt_fault[c], evt_done[c]}),
         .set_we  (we_en_set & sel),
         .clr_we  (we_en_clr & sel),
         .fclr_we (we_flag_clr & sel),
         .wbits   (wr_bits),
         .flags_q (flag_arr[c]),
         .en_q    (en_arr[c]),
         .req     (chan_pend[c])
      );
   end

   always_comb begin
      rd_flags   = '0;
      rd_enables = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (acc_ch == CH_W'(c)) begin
            rd_flags   = flag_arr[c];
            rd_enables = en_arr[c];
         end
      end
   end

   assign irq_out = glob_ie & (|chan_pend);

   logic            enc_hit;
   logic [CH_W-1:0] enc_idx;
   src_vec_t        enc_flags;

   irq_low_enc #(.N(NUM_CH)) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_vec (chan_pend),
      .hit     (enc_hit),
      .idx     (enc_idx)
   );

   always_comb begin
      enc_flags = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (enc_hit && enc_idx == CH_W'(c)) enc_flags = flag_arr[c];
      end
   end

   if (REG_PEND == 1) begin : g_pend_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_ch    <= '0;
            pend_flags <= '0;
         end else begin
            pend_valid <= enc_hit;
            pend_ch    <= enc_idx;
            pend_flags <= enc_flags;
         end
      end
   end else begin : g_pend_comb
      assign pend_valid = enc_hit;
      assign pend_ch    = enc_idx;
      assign pend_flags = enc_flags;
   end

   // R5
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_ie |-> !irq_out);
   // R5
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (chan_pend != '0));
endmodule

// File: tb/sim_dma_irq_aggregator.sv
module sim_dma_irq_aggregator;
   localparam int N = 8;

   typedef struct packed {
      logic [1:0] op;    // 0 event, 1 enable set, 2 enable clear, 3 flag clear
      logic [2:0] ch;
      logic [2:0] bits;
      logic [7:0] vec;
      logic       irq;
      logic       pv;
      logic [2:0] pch;
      logic [2:0] pf;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{2'd0, 3'd5, 3'b001, 8'h00, 1'b0, 1'b0, 3'd0, 3'b000},
      '{2'd1, 3'd5, 3'b011, 8'h20, 1'b1, 1'b1, 3'd5, 3'b001},
      '{2'd0, 3'd2, 3'b100, 8'h20, 1'b1, 1'b1, 3'd5, 3'b001},
      '{2'd1, 3'd2, 3'b100, 8'h24, 1'b1, 1'b1, 3'd2, 3'b100},
      '{2'd0, 3'd2, 3'b010, 8'h24, 1'b1, 1'b1, 3'd2, 3'b110},
      '{2'd3, 3'd2, 3'b100, 8'h20, 1'b1, 1'b1, 3'd5, 3'b001},
      '{2'd2, 3'd5, 3'b001, 8'h00, 1'b0, 1'b0, 3'd0, 3'b000},
      '{2'd0, 3'd5, 3'b010, 8'h20, 1'b1, 1'b1, 3'd5, 3'b011},
      '{2'd1, 3'd2, 3'b010, 8'h24, 1'b1, 1'b1, 3'd2, 3'b010},
      '{2'd3, 3'd2, 3'b000, 8'h24, 1'b1, 1'b1, 3'd2, 3'b010},
      '{2'd1, 3'd0, 3'b111, 8'h24, 1'b1, 1'b1, 3'd2, 3'b010},
      '{2'd0, 3'd0, 3'b100, 8'h25, 1'b1, 1'b1, 3'd0, 3'b100}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] ch_rst = '0, evt_done = '0, evt_fault = '0, evt_halt = '0;
   logic [2:0]   acc_ch = '0, wr_bits = '0;
   logic         we_en_set = 1'b0, we_en_clr = 1'b0, we_flag_clr = 1'b0;
   logic         glob_ie = 1'b1;
   logic [2:0]   rd_flags, rd_enables, pend_ch, pend_flags;
   logic         irq_out, pend_valid;
   logic [N-1:0] chan_pend;

   int checks = 0;
   int fails  = 0;
   bit done_run = 1'b0;

   always #10 clk = ~clk;

   dma_irq_aggregator #(.NUM_CH(N)) u0 (
      .clk(clk), .rst_n(rst_n), .ch_rst(ch_rst),
      .evt_done(evt_done), .evt_fault(evt_fault), .evt_halt(evt_halt),
      .acc_ch(acc_ch), .wr_bits(wr_bits),
      .we_en_set(we_en_set), .we_en_clr(we_en_clr), .we_flag_clr(we_flag_clr),
      .rd_flags(rd_flags), .rd_enables(rd_enables), .glob_ie(glob_ie),
      .irq_out(irq_out), .chan_pend(chan_pend), .pend_valid(pend_valid),
      .pend_ch(pend_ch), .pend_flags(pend_flags)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic [2:0] ch, input logic [2:0] bits);
      acc_ch  = ch;
      wr_bits = bits;
      case (op)
         2'd0: begin
            evt_done[ch]  = bits[0];
            evt_fault[ch] = bits[1];
            evt_halt[ch]  = bits[2];
         end
         2'd1: we_en_set   = 1'b1;
         2'd2: we_en_clr   = 1'b1;
         default: we_flag_clr = 1'b1;
      endcase
   endtask

   task automatic idle();
      evt_done = '0; evt_fault = '0; evt_halt = '0; ch_rst = '0;
      we_en_set = 1'b0; we_en_clr = 1'b0; we_flag_clr = 1'b0;
   endtask

   task automatic one_edge();
      @(negedge clk);
      idle();
      #1;
   endtask

   task automatic pend_chk(input string req, input logic [7:0] vec, input logic irq,
                           input logic pv, input logic [2:0] pch, input logic [2:0] pf);
      chk(req, "chan_pend", 32'(chan_pend), 32'(vec));
      chk(req, "irq_out", 32'(irq_out), 32'(irq));
      chk(req, "pend_valid", 32'(pend_valid), 32'(pv));
      chk(req, "pend_ch", 32'(pend_ch), 32'(pch));
      chk(req, "pend_flags", 32'(pend_flags), 32'(pf));
   endtask

   initial begin
      #(20 * 200000);
      if (!done_run) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R8: reset state
      pend_chk("R8", 8'h00, 1'b0, 1'b0, 3'd0, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4 R5 R6: table walk
      for (int k = 0; k < NV; k++) begin
         drive(TBL[k].op, TBL[k].ch, TBL[k].bits);
         one_edge();
         pend_chk($sformatf("R4/R6 step%0d", k), TBL[k].vec, TBL[k].irq,
                  TBL[k].pv, TBL[k].pch, TBL[k].pf);
      end

      // R9: read back channel 2 (flags halt-cleared, fault set; enables fault+halt)
      acc_ch = 3'd2; #1;
      chk("R9", "rd_flags ch2", 32'(rd_flags), 32'h2);
      chk("R9", "rd_enables ch2", 32'(rd_enables), 32'h6);

      // R1: done event on channel 7 with all enables
      drive(2'd1, 3'd7, 3'b111); one_edge();
      drive(2'd0, 3'd7, 3'b001); one_edge();
      chk("R1", "chan_pend", 32'(chan_pend), 32'hA5);

      // R2: event and clear of the same bit in one cycle, event wins
      drive(2'd0, 3'd7, 3'b001);
      we_flag_clr = 1'b1;
      one_edge();
      chk("R2", "rd_flags ch7 collide", 32'(rd_flags), 32'h1);
      drive(2'd3, 3'd7, 3'b001); one_edge();
      chk("R2", "rd_flags ch7 cleared", 32'(rd_flags), 32'h0);
      chk("R2", "chan_pend", 32'(chan_pend), 32'h25);

      // R3: set and clear of bit1 together, clear wins
      drive(2'd1, 3'd7, 3'b010);
      we_en_clr = 1'b1;
      one_edge();
      chk("R3", "rd_enables ch7", 32'(rd_enables), 32'h5);

      // R5: global gate masks only irq_out
      glob_ie = 1'b0; #1;
      chk("R5", "irq_out gated", 32'(irq_out), 32'h0);
      chk("R5", "chan_pend gated", 32'(chan_pend), 32'h25);
      glob_ie = 1'b1; #1;
      chk("R5", "irq_out ungated", 32'(irq_out), 32'h1);

      // R7: channel reset on 0 together with an event on 0
      @(negedge clk);
      ch_rst[0] = 1'b1;
      evt_halt[0] = 1'b1;
      acc_ch = 3'd0;
      one_edge();
      chk("R7", "rd_flags ch0", 32'(rd_flags), 32'h0);
      chk("R7", "rd_enables ch0", 32'(rd_enables), 32'h0);
      pend_chk("R7", 8'h24, 1'b1, 1'b1, 3'd2, 3'b010);
      acc_ch = 3'd5; #1;
      chk("R7", "rd_flags ch5 kept", 32'(rd_flags), 32'h3);

      // R8: global reset clears every channel
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      pend_chk("R8", 8'h00, 1'b0, 1'b0, 3'd0, 3'b000);
      chk("R8", "rd_flags ch5", 32'(rd_flags), 32'h0);
      chk("R8", "rd_enables ch5", 32'(rd_enables), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      done_run = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule